// File: doc/BRIEF.md
# Two-Channel Chunked DMA Link Arbiter

This block is the front end of a DMA engine whose single physical link is shared by two kinds of traffic: compute tile movement (loads, stores, writebacks) and inter-core queue send data. Requests arrive on one ready/valid port. A one-bit kind tag on each request steers it into one of two virtual channels. Each channel has its own 4-entry request queue and its own state machine. The state machine cuts a transfer into fixed-size chunks.

A weighted round-robin arbiter hands the link to one chunk per cycle. Because of this, a short communication transfer slips in between the chunks of a long compute transfer and is not stuck behind it. A channel with no chunk ready gives up its turn at once, so the link never idles while the other channel has work.

On the receive side, the final piece of an arriving communication transfer produces the data-write completion and the metadata strobe toward the local queue controller in the same cycle.

Top module: `dma_vc_arbiter`

## Requirements
- R1: A request with `req_kind`=0 is served on the compute channel and its link beats carry `link_vc`=0. With `req_kind`=1 it is served on the communication channel and its beats carry `link_vc`=1.
- R2: Each channel holds up to 4 waiting requests plus one in service. `req_ready` is low while the queue selected by `req_kind` is full.
- R3: A full compute queue does not stop the communication queue from accepting requests and issuing beats.
- R4: Every link beat carries a byte count between 1 and `CHUNK_BYTES`. Every beat that is not final carries exactly `CHUNK_BYTES`.
- R5: A transfer of L bytes (L ≥ 1) produces ceil(L/`CHUNK_BYTES`) beats. Only the final beat has `link_last`=1, and that beat carries L − (beats−1)·`CHUNK_BYTES` bytes.
- R6: While both channels have chunks ready, the link gives `W_COMP` consecutive beats to compute and then `W_COMM` to communication, repeating.
- R7: In every cycle after a channel has a chunk ready, a beat is issued. A single active channel gets back-to-back beats.
- R8: `done_vec[c]` pulses in exactly the cycle of channel c's final beat (bit 0 compute, bit 1 communication), and at no other time.
- R9: `rx_valid` with `rx_last` raises `rx_wr_done` and `rx_meta_valid` together one cycle later, with `rx_meta_out` equal to the `rx_meta` presented. `rx_valid` without `rx_last` raises neither.
- R10: After reset `link_valid`, `done_vec`, `rx_wr_done` and `rx_meta_valid` are low and `req_ready` is high.
- R11: A communication transfer submitted just after a long compute transfer completes before that compute transfer's final beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Selected channel queue has room |
| req_kind | input | 1 | 0 compute, 1 communication |
| req_len | input | LEN_W | Transfer length in bytes, nonzero |
| req_id | input | ID_W | Transfer tag |
| link_valid | output | 1 | A chunk is on the link this cycle |
| link_vc | output | 1 | Channel owning the chunk |
| link_id | output | ID_W | Tag of the transfer |
| link_len | output | LEN_W | Bytes in this chunk |
| link_last | output | 1 | Final chunk of the transfer |
| done_vec | output | 2 | Per-channel transfer completion pulse |
| rx_valid | input | 1 | Incoming communication piece written |
| rx_last | input | 1 | Piece is the final one of its transfer |
| rx_meta | input | META_W | Queue metadata carried with the transfer |
| rx_wr_done | output | 1 | Data write of an incoming transfer complete |
| rx_meta_valid | output | 1 | Metadata forwarded to queue controller |
| rx_meta_out | output | META_W | Forwarded metadata |

## Verification
The chunking is tried with single transfers on each channel. The lengths are one byte, an exact chunk, one byte past a chunk, exact multiples and ragged remainders. These separate off-by-one errors in the beat count from errors in the final-length remainder.

The arbitration is tried with two overlapping long transfers under equal and 3:1 weights. The observed beat order separates a correct grant counter from one that forfeits or overruns its share.

A burst that fills the compute queue, followed by a short communication transfer, shows both the queue depth and that the two channels progress independently. Receive pieces with and without the final flag show that the completion and the metadata strobe move together.

// File: rtl/dma_vc_pkg.sv
package dma_vc_pkg;
  typedef enum logic {VC_COMPUTE = 1'b0, VC_COMM = 1'b1} vc_e;
  typedef enum logic {CH_IDLE = 1'b0, CH_BUSY = 1'b1} ch_state_e;
  localparam int NUM_VC = 2;
endpackage

// File: rtl/dma_vc_fifo.sv
module dma_vc_fifo #(
  parameter int WIDTH = 20,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign dout  = mem[rd_ptr];
  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) count <= CNT_W'(DEPTH)); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> !empty); // R2
endmodule

// File: rtl/dma_vc_chan.sv
module dma_vc_chan
  import dma_vc_pkg::*;
#(
  parameter int CHUNK_BYTES = 256,
  parameter int LEN_W       = 16,
  parameter int ID_W        = 4,
  parameter int DEPTH       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [LEN_W-1:0] in_len,
  input  logic [ID_W-1:0]  in_id,
  output logic             full,
  output logic             pend,
  input  logic             grant,
  output logic [LEN_W-1:0] chunk_len,
  output logic             chunk_last,
  output logic [ID_W-1:0]  xfer_id
);
  localparam int ENT_W = LEN_W + ID_W;
  localparam logic [LEN_W-1:0] CHUNK = LEN_W'(CHUNK_BYTES);

  logic [ENT_W-1:0] head;
  logic             empty, pop;
  ch_state_e        state;
  logic [LEN_W-1:0] rem;

  dma_vc_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) q_i (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .din({in_id, in_len}), .dout(head), .full(full), .empty(empty)
  );

  assign pop        = (state == CH_IDLE) && !empty;
  assign pend       = (state == CH_BUSY);
  assign chunk_last = (rem <= CHUNK);
  assign chunk_len  = chunk_last ? rem : CHUNK;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= CH_IDLE;
      rem     <= '0;
      xfer_id <= '0;
    end else if (pop) begin
      state   <= CH_BUSY;
      rem     <= head[LEN_W-1:0];
      xfer_id <= head[ENT_W-1:LEN_W];
    end else if (grant) begin
      if (chunk_last) state <= CH_IDLE;
      else            rem   <= rem - CHUNK;
    end
  end

  AST_GRANT_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst) grant |-> pend); // R7
  AST_REM_STEP: assert property (@(posedge clk) disable iff (rst)
    (pend && grant && !chunk_last) |=> (rem == $past(rem) - CHUNK)); // R4
  AST_BUSY_NONZERO: assert property (@(posedge clk) disable iff (rst) pend |-> (rem != '0)); // R5
endmodule

// File: rtl/dma_vc_wrr.sv
module dma_vc_wrr #(
  parameter int W_COMP = 1,
  parameter int W_COMM = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] pend,
  output logic [1:0] gnt
);
  localparam int WMAX  = (W_COMP > W_COMM) ? W_COMP : W_COMM;
  localparam int CNT_W = $clog2(WMAX + 1);

  logic             turn, nturn, other;
  logic [CNT_W-1:0] cnt, ncnt, wt;

  always_comb begin
    other = ~turn;
    wt    = turn ? CNT_W'(W_COMM) : CNT_W'(W_COMP);
    gnt   = '0;
    nturn = turn;
    ncnt  = cnt;
    if (pend[turn] && (cnt < wt)) begin
      gnt[turn] = 1'b1;
      ncnt      = cnt + 1'b1;
    end else if (pend[other]) begin
      gnt[other] = 1'b1;
      nturn      = other;
      ncnt       = CNT_W'(1);
    end else if (pend[turn]) begin
      gnt[turn] = 1'b1;
      ncnt      = CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      turn <= 1'b0;
      cnt  <= '0;
    end else begin
      turn <= nturn;
      cnt  <= ncnt;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt)); // R6
  AST_WORK_CONSERVE: assert property (@(posedge clk) disable iff (rst) (|pend) |-> (|gnt)); // R7
  AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (rst) (gnt & ~pend) == 2'b00); // R7
  AST_SHARE_BOUND: assert property (@(posedge clk) disable iff (rst) cnt <= CNT_W'(WMAX)); // R6
endmodule

// File: rtl/dma_vc_rx.sv
module dma_vc_rx #(
  parameter int META_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic              rx_last,
  input  logic [META_W-1:0] rx_meta,
  output logic              rx_wr_done,
  output logic              rx_meta_valid,
  output logic [META_W-1:0] rx_meta_out
);
  logic fin;
  assign fin = rx_valid && rx_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_wr_done    <= 1'b0;
      rx_meta_valid <= 1'b0;
      rx_meta_out   <= '0;
    end else begin
      rx_wr_done    <= fin;
      rx_meta_valid <= fin;
      if (fin) rx_meta_out <= rx_meta;
    end
  end

  AST_RX_ATOMIC: assert property (@(posedge clk) disable iff (rst) rx_wr_done == rx_meta_valid); // R9
  AST_RX_META: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_last) |=> (rx_meta_valid && rx_meta_out == $past(rx_meta))); // R9
endmodule

// File: rtl/dma_vc_arbiter.sv
module dma_vc_arbiter
  import dma_vc_pkg::*;
#(
  parameter int CHUNK_BYTES = 256,
  parameter int LEN_W       = 16,
  parameter int ID_W        = 4,
  parameter int DEPTH       = 4,
  parameter int W_COMP      = 1,
  parameter int W_COMM      = 1,
  parameter int META_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_kind,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [ID_W-1:0]   req_id,
  output logic              link_valid,
  output logic              link_vc,
  output logic [ID_W-1:0]   link_id,
  output logic [LEN_W-1:0]  link_len,
  output logic              link_last,
  output logic [1:0]        done_vec,
  input  logic              rx_valid,
  input  logic              rx_last,
  input  logic [META_W-1:0] rx_meta,
  output logic              rx_wr_done,
  output logic              rx_meta_valid,
  output logic [META_W-1:0] rx_meta_out
);
  localparam logic [LEN_W-1:0] CHUNK = LEN_W'(CHUNK_BYTES);

  logic [NUM_VC-1:0] full, pend, gnt, clast;
  logic [LEN_W-1:0]  clen [NUM_VC];
  logic [ID_W-1:0]   cid  [NUM_VC];

  assign req_ready = !full[req_kind];

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    dma_vc_chan #(
      .CHUNK_BYTES(CHUNK_BYTES), .LEN_W(LEN_W), .ID_W(ID_W), .DEPTH(DEPTH)
    ) chan_i (
      .clk(clk), .rst(rst),
      .push(req_valid && !full[v] && (req_kind == 1'(v))),
      .in_len(req_len), .in_id(req_id),
      .full(full[v]), .pend(pend[v]), .grant(gnt[v]),
      .chunk_len(clen[v]), .chunk_last(clast[v]), .xfer_id(cid[v])
    );
  end

  dma_vc_wrr #(.W_COMP(W_COMP), .W_COMM(W_COMM)) wrr_i (
    .clk(clk), .rst(rst), .pend(pend), .gnt(gnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      link_valid <= 1'b0;
      link_vc    <= VC_COMPUTE;
      link_id    <= '0;
      link_len   <= '0;
      link_last  <= 1'b0;
      done_vec   <= '0;
    end else begin
      link_valid <= |gnt;
      link_vc    <= gnt[VC_COMM];
      link_id    <= gnt[VC_COMM] ? cid[VC_COMM]   : cid[VC_COMPUTE];
      link_len   <= gnt[VC_COMM] ? clen[VC_COMM]  : clen[VC_COMPUTE];
      link_last  <= gnt[VC_COMM] ? clast[VC_COMM] : clast[VC_COMPUTE];
      done_vec   <= gnt & clast;
    end
  end

  dma_vc_rx #(.META_W(META_W)) rx_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_last(rx_last), .rx_meta(rx_meta),
    .rx_wr_done(rx_wr_done), .rx_meta_valid(rx_meta_valid), .rx_meta_out(rx_meta_out)
  );

  AST_REQ_NONZERO: assert property (@(posedge clk) disable iff (rst) req_valid |-> (req_len != '0)); // R5
  AST_CHUNK_RANGE: assert property (@(posedge clk) disable iff (rst)
    link_valid |-> (link_len != '0 && link_len <= CHUNK)); // R4
  AST_FULL_MIDDLE: assert property (@(posedge clk) disable iff (rst)
    (link_valid && !link_last) |-> (link_len == CHUNK)); // R4
  AST_DONE_WITH_LAST: assert property (@(posedge clk) disable iff (rst)
    (|done_vec) |-> (link_valid && link_last && done_vec[link_vc])); // R8
  AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(done_vec)); // R8
endmodule

// File: tb/dma_vc_arbiter_tb_top.sv
`timescale 1ns/1ps
module dma_vc_arbiter_tb_top;
  localparam int LEN_W = 16, ID_W = 4, META_W = 8, CH = 256;

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic req_valid = 0, req_kind = 0, req_ready;
  logic [LEN_W-1:0] req_len = '0;
  logic [ID_W-1:0] req_id = '0;
  logic link_valid, link_vc, link_last;
  logic [ID_W-1:0] link_id;
  logic [LEN_W-1:0] link_len;
  logic [1:0] done_vec;
  logic rx_valid = 0, rx_last = 0, rx_wr_done, rx_meta_valid;
  logic [META_W-1:0] rx_meta = '0, rx_meta_out;

  logic wreq_valid = 0, wreq_kind = 0, wreq_ready;
  logic [LEN_W-1:0] wreq_len = '0;
  logic wlink_valid, wlink_vc, wlink_last, wrx_done, wrx_mv;
  logic [ID_W-1:0] wlink_id;
  logic [LEN_W-1:0] wlink_len;
  logic [1:0] wdone;
  logic [META_W-1:0] wrx_meta;

  dma_vc_arbiter dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_len(req_len), .req_id(req_id), .link_valid(link_valid), .link_vc(link_vc),
    .link_id(link_id), .link_len(link_len), .link_last(link_last), .done_vec(done_vec),
    .rx_valid(rx_valid), .rx_last(rx_last), .rx_meta(rx_meta), .rx_wr_done(rx_wr_done),
    .rx_meta_valid(rx_meta_valid), .rx_meta_out(rx_meta_out));

  dma_vc_arbiter #(.W_COMP(3), .W_COMM(1)) dut_w (
    .clk(clk), .rst(rst), .req_valid(wreq_valid), .req_ready(wreq_ready), .req_kind(wreq_kind),
    .req_len(wreq_len), .req_id(4'd0), .link_valid(wlink_valid), .link_vc(wlink_vc),
    .link_id(wlink_id), .link_len(wlink_len), .link_last(wlink_last), .done_vec(wdone),
    .rx_valid(1'b0), .rx_last(1'b0), .rx_meta(8'd0), .rx_wr_done(wrx_done),
    .rx_meta_valid(wrx_mv), .rx_meta_out(wrx_meta));

  int ntot = 0, nbad = 0, cyc = 0;
  int nb = 0, wnb = 0;
  int lvc[1024], llen[1024], llast[1024], lcyc[1024], wvc[64];

  task automatic chk(bit ok, string req, int act, int exp);
    ntot++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // beat monitor; R8 done pulse checked on every cycle
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (link_valid && nb < 1024) begin
        lvc[nb] = link_vc; llen[nb] = link_len; llast[nb] = link_last; lcyc[nb] = cyc; nb++;
      end
      if (wlink_valid && wnb < 64) begin wvc[wnb] = wlink_vc; wnb++; end
      chk(done_vec == ((link_valid && link_last) ? (link_vc ? 2'b10 : 2'b01) : 2'b00),
          "R8 done_vec", done_vec, (link_valid && link_last) ? (link_vc ? 2 : 1) : 0);
    end
    if (cyc > 100000) begin
      nbad++; ntot++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end

  task automatic send(bit kind, int len, int id);
    req_valid = 1; req_kind = kind; req_len = LEN_W'(len); req_id = ID_W'(id);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wsend(bit kind, int len);
    wreq_valid = 1; wreq_kind = kind; wreq_len = LEN_W'(len);
    #1;
    while (!wreq_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    wreq_valid = 0;
  endtask

  // kind in bit 16, length below
  localparam int NV = 7;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 16'd1}, {1'b0, 16'd256}, {1'b0, 16'd257}, {1'b1, 16'd700},
    {1'b1, 16'd512}, {1'b0, 16'd1000}, {1'b1, 16'd255}};

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R10 reset state
    chk(req_ready == 1, "R10 req_ready", req_ready, 1);
    chk(link_valid == 0, "R10 link_valid", link_valid, 0);
    chk(done_vec == 0, "R10 done_vec", done_vec, 0);
    chk(rx_wr_done == 0 && rx_meta_valid == 0, "R10 rx outputs", rx_wr_done, 0);
    @(negedge clk);

    // table: single transfers, R1 R4 R5 R7
    for (int v = 0; v < NV; v++) begin
      int base, n, len, expl;
      bit kind;
      kind = VEC[v][16]; len = int'(VEC[v][15:0]);
      n = (len + CH - 1) / CH; expl = len - (n - 1) * CH;
      base = nb;
      send(kind, len, v);
      repeat (n + 6) @(negedge clk);
      chk(nb - base == n, "R5 beat count", nb - base, n);
      for (int j = 0; j < n; j++) begin
        chk(lvc[base+j] == int'(kind), "R1 channel", lvc[base+j], int'(kind));
        if (j == n - 1) begin
          chk(llen[base+j] == expl, "R5 final length", llen[base+j], expl);
          chk(llast[base+j] == 1, "R5 last flag", llast[base+j], 1);
        end else begin
          chk(llen[base+j] == CH, "R4 full chunk", llen[base+j], CH);
          chk(llast[base+j] == 0, "R5 early last", llast[base+j], 0);
        end
      end
      chk(lcyc[base+n-1] - lcyc[base] == n - 1, "R7 back-to-back", lcyc[base+n-1] - lcyc[base], n - 1);
    end

    // R6 equal weights: alternating beats
    begin
      int base; base = nb;
      send(0, 1024, 1); send(1, 1024, 2);
      repeat (20) @(negedge clk);
      for (int j = 0; j < 8; j++)
        chk(lvc[base+j] == (j % 2), "R6 equal share order", lvc[base+j], j % 2);
    end

    // R6 weighted 3:1 on second instance
    wsend(0, 4096); wsend(1, 4096);
    repeat (12) @(negedge clk);
    for (int j = 0; j < 8; j++)
      chk(wvc[j] == ((j % 4) == 3 ? 1 : 0), "R6 weighted order", wvc[j], (j % 4) == 3 ? 1 : 0);

    // R2 queue depth, R3 independence, R11 interleave
    begin
      int base, acc, lastc, lastm, ncomp;
      base = nb; acc = 0; lastc = -1; lastm = -1; ncomp = 0;
      req_valid = 1; req_kind = 0; req_len = 16'd4096;
      for (int i = 0; i < 8; i++) begin
        #1; if (req_ready) acc++;
        @(negedge clk);
      end
      req_valid = 0;
      #1;
      chk(acc == 5, "R2 accepted before full", acc, 5);
      chk(req_ready == 0, "R2 ready low when full", req_ready, 0);
      req_kind = 1;
      #1;
      chk(req_ready == 1, "R3 comm ready while compute full", req_ready, 1);
      @(negedge clk);
      send(1, 300, 7);
      repeat (300) @(negedge clk);
      for (int j = base; j < nb; j++) begin
        if (lvc[j] == 0) begin ncomp++; if (llast[j] == 1) lastc = j; end
        else if (llast[j] == 1) lastm = j;
      end
      chk(ncomp == 80, "R2 compute beats drained", ncomp, 80);
      chk(lastm >= 0 && lastm < lastc, "R11 comm done first", lastm, lastc);
    end

    // R9 receive side
    rx_valid = 1; rx_last = 1; rx_meta = 8'hA5;
    @(negedge clk);
    rx_valid = 0; rx_last = 0;
    chk(rx_wr_done == 1, "R9 write done", rx_wr_done, 1);
    chk(rx_meta_valid == 1, "R9 meta strobe", rx_meta_valid, 1);
    chk(rx_meta_out == 8'hA5, "R9 meta value", rx_meta_out, 8'hA5);
    rx_valid = 1; rx_last = 0; rx_meta = 8'h3C;
    @(negedge clk);
    rx_valid = 0;
    chk(rx_wr_done == 0 && rx_meta_valid == 0, "R9 no strobe mid-transfer", rx_meta_valid, 0);

    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule